// File: doc/BRIEF.md
# Reference-Gated Frequency Ratio Meter

This block measures how fast a clock runs compared with a reference clock. The reference clock first goes into a range reduction. A 2-bit range code says which octave band the reference occupies, and the block divides the reference by 2^code so that it falls into the base band. The block then opens a gate that lasts a fixed number of these divided cycles. While the gate is open it counts rising edges of the measured clock. The final count is therefore the frequency ratio multiplied by 2^(GATE_LOG2+code). GATE_LOG2 defaults to 14.

The counter runs in the measured clock's own domain. The gate level crosses into that domain through a two-flop synchronizer. The finished count comes back to the reference domain with a toggle request, and the block raises `done` once that request arrives. Software-facing control is reduced to three inputs: a level-sensitive enable, a start bit that the host writes 1 and then 0, and the range code. A loss-of-lock input qualifies the result. The 23-bit result is shown as three bytes.

Top module: `freq_ratio_meter`

## Requirements
- R1: With range code c (0..3), the gate stays open for exactly 2^(GATE_LOG2+c) reference cycles. With a 32 MHz reference, code 1, GATE_LOG2=14 and a 1.25 GHz measured clock, the result reads 0x138800.
- R2: When the gate length is a whole number of measured periods, the result equals the number of measured-clock rising edges in the gate window. That number is ratio × 2^(GATE_LOG2+c).
- R3: The result is shown as three bytes. `rate_hi` holds bits 22..16 in its bits 6..0, and its bit 7 is always 0. `rate_mid` holds bits 15..8. `rate_lo` holds bits 7..0.
- R4: `meas_enable` is level-sensitive. While it is low, start sequences are ignored and `done` and the result keep their values. While it stays high, one measurement follows another with no re-arming.
- R5: While `start_bit` is 1 (and enable is 1), `done` and `invalid` read 0. The 1-to-0 transition of `start_bit` begins a new count.
- R6: `done` stays 0 while a count is in progress. It becomes 1 only when the result holds the complete count, and it then stays 1 with a stable result until the next start sequence.
- R7: `invalid` latches to 1 if `lol_in` is high in any cycle of the gate window. It clears on the next start sequence.
- R8: A count that would go past the counter width (CNT_W, default 23) stops at all-ones instead of wrapping.
- R9: A change of the range code while a measurement is running aborts that measurement. `done` then stays 0 until the next start sequence.
- R10: `ratio_valid` is 1 only when `done` is 1, `invalid` is 0 and the synchronized `lol_in` is currently low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the control inputs are synchronous to it |
| meas_clk | input | 1 | Clock whose rate is measured |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| range_code | input | 2 | Reference band select; the divider is 2^code |
| meas_enable | input | 1 | Level enable for the measurement function |
| start_bit | input | 1 | Start control; writing 1 then 0 begins a count |
| lol_in | input | 1 | Loss-of-lock indication, asynchronous |
| rate_hi | output | 8 | Result bits 22..16 in bits 6..0 |
| rate_mid | output | 8 | Result bits 15..8 |
| rate_lo | output | 8 | Result bits 7..0 |
| done | output | 1 | Result complete |
| invalid | output | 1 | Loss of lock was seen during the gate window |
| ratio_valid | output | 1 | Done, not invalid, and lock currently held |

## Verification
A gate counter that closes one cycle too early or too late shows up directly in the bytes. It moves the count by the ratio times the error, and this is visible as soon as `done` rises, a few reference cycles after the window ends. A synchronizer or handshake fault shows as `done` rising too early, in the middle of the window, or never rising. A stuck state after an abort, or an invalid flag that does not latch, shows as a wrong `done` or `invalid` within one gate length of the next start. Saturation faults appear only when the count goes past the counter width, so that case is driven on purpose with a narrow counter.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_GATE, ST_WAIT, ST_DONE} frm_state_e;

  localparam int RES_W = 23;

  // raw reference cycles in one gate window
  function automatic int unsigned gate_cycles(input int unsigned base_log2, input logic [1:0] code);
    return 32'd1 << (base_log2 + int'(code));
  endfunction

  function automatic logic [7:0] res_hi(input logic [RES_W-1:0] r);
    return {1'b0, r[22:16]};
  endfunction

  function automatic logic [7:0] res_mid(input logic [RES_W-1:0] r);
    return r[15:8];
  endfunction

  function automatic logic [7:0] res_lo(input logic [RES_W-1:0] r);
    return r[7:0];
  endfunction
endpackage

// File: rtl/frm_sync.sv
module frm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_sync <= '0;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/frm_meas_cnt.sv
module frm_meas_cnt #(
  parameter int CNT_W = 23
) (
  input  logic             meas_clk,
  input  logic             rst_n,
  input  logic             gate_async,
  output logic [CNT_W-1:0] cnt_hold,
  output logic             req_tgl
);
  logic             gate_s;
  logic             gate_d;
  logic [CNT_W-1:0] run_cnt;
  logic             open_evt;
  logic             close_evt;
  logic             at_max;

  frm_sync #(.W(1)) u_gate_sync (
    .clk(meas_clk), .rst_n(rst_n), .d_async(gate_async), .q_sync(gate_s)
  );

  assign open_evt  = gate_s & ~gate_d;
  assign close_evt = ~gate_s & gate_d;
  assign at_max    = (run_cnt == {CNT_W{1'b1}});

  always_ff @(posedge meas_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d   <= 1'b0;
      run_cnt  <= '0;
      cnt_hold <= '0;
      req_tgl  <= 1'b0;
    end else begin
      gate_d <= gate_s;
      if (open_evt)
        run_cnt <= CNT_W'(1);
      else if (gate_s && !at_max)
        run_cnt <= run_cnt + CNT_W'(1);
      if (close_evt) begin
        cnt_hold <= run_cnt;
        req_tgl  <= ~req_tgl;
      end
    end
  end

  // R8: the counter holds at all-ones while the window stays open
  p_sat_hold_r8: assert property (@(posedge meas_clk) disable iff (!rst_n)
    (at_max && gate_s && gate_d) |=> (run_cnt == {CNT_W{1'b1}}));

  // R2: a result is handed over only at a window close
  p_req_on_close_r2: assert property (@(posedge meas_clk) disable iff (!rst_n)
    !$stable(req_tgl) |-> ($past(gate_d) && !$past(gate_s)));
endmodule

// File: rtl/frm_ref_ctrl.sv
module frm_ref_ctrl
  import frm_pkg::*;
#(
  parameter int GATE_LOG2 = 14,
  parameter int CNT_W     = 23
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [1:0]       range_code,
  input  logic             meas_enable,
  input  logic             start_bit,
  input  logic             lol_in,
  input  logic             req_tgl,
  input  logic [CNT_W-1:0] cnt_hold,
  output logic             gate_o,
  output logic             done,
  output logic             invalid,
  output logic             lol_s,
  output logic [RES_W-1:0] result
);
  localparam int GW = GATE_LOG2 + 4;

  frm_state_e  state;
  logic [1:0]  code_q;
  logic [GW-1:0] gate_cnt;
  logic        start_q;
  logic        req_s;
  logic        req_seen;
  logic        start_hold;
  logic        start_go;
  logic        running;
  logic        abort_evt;
  logic        gate_last;
  logic        req_evt;

  frm_sync #(.W(2)) u_ref_sync (
    .clk(ref_clk), .rst_n(rst_n), .d_async({req_tgl, lol_in}), .q_sync({req_s, lol_s})
  );

  assign start_hold = meas_enable & start_bit;
  assign start_go   = meas_enable & start_q & ~start_bit;
  assign running    = (state == ST_GATE) || (state == ST_WAIT);
  assign abort_evt  = running && ((range_code != code_q) || !meas_enable);
  assign gate_last  = (state == ST_GATE) &&
                      (gate_cnt == GW'(gate_cycles(GATE_LOG2, code_q) - 1));
  assign req_evt    = req_s ^ req_seen;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      code_q   <= 2'd0;
      gate_cnt <= '0;
      gate_o   <= 1'b0;
      done     <= 1'b0;
      invalid  <= 1'b0;
      result   <= '0;
      start_q  <= 1'b0;
      req_seen <= 1'b0;
    end else begin
      start_q  <= start_bit;
      req_seen <= req_s;
      if (start_hold) begin
        state   <= ST_IDLE;
        gate_o  <= 1'b0;
        done    <= 1'b0;
        invalid <= 1'b0;
      end else if (start_go) begin
        state    <= ST_GATE;
        gate_o   <= 1'b1;
        gate_cnt <= '0;
        code_q   <= range_code;
      end else if (abort_evt) begin
        state  <= ST_IDLE;
        gate_o <= 1'b0;
      end else begin
        unique case (state)
          ST_GATE: begin
            gate_cnt <= gate_cnt + GW'(1);
            if (lol_s) invalid <= 1'b1;
            if (gate_last) begin
              gate_o <= 1'b0;
              state  <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (req_evt) begin
              result <= RES_W'(cnt_hold);
              done   <= 1'b1;
              state  <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5: writing the start bit to 1 clears the status
  p_start_clears_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    start_hold |=> (!done && !invalid));

  // R9: a range change during a measurement closes the gate, done stays low
  p_range_abort_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (abort_evt && !start_hold) |=> (!gate_o && !done));

  // R7: loss of lock inside the window latches invalid
  p_lol_latch_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((state == ST_GATE) && lol_s && !start_hold && !start_go && !abort_evt) |=> invalid);

  // R6: a finished result stays put until the host starts again
  p_done_hold_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (done && !start_hold) |=> (done && $stable(result)));
endmodule

// File: rtl/freq_ratio_meter.sv
module freq_ratio_meter
  import frm_pkg::*;
#(
  parameter int GATE_LOG2 = 14,
  parameter int CNT_W     = 23
) (
  input  logic       ref_clk,
  input  logic       meas_clk,
  input  logic       rst_n,
  input  logic [1:0] range_code,
  input  logic       meas_enable,
  input  logic       start_bit,
  input  logic       lol_in,
  output logic [7:0] rate_hi,
  output logic [7:0] rate_mid,
  output logic [7:0] rate_lo,
  output logic       done,
  output logic       invalid,
  output logic       ratio_valid
);
  logic             gate_w;
  logic             req_w;
  logic             lol_sw;
  logic [CNT_W-1:0] hold_w;
  logic [RES_W-1:0] result_w;

  frm_meas_cnt #(.CNT_W(CNT_W)) u_meas (
    .meas_clk(meas_clk), .rst_n(rst_n), .gate_async(gate_w),
    .cnt_hold(hold_w), .req_tgl(req_w)
  );

  frm_ref_ctrl #(.GATE_LOG2(GATE_LOG2), .CNT_W(CNT_W)) u_ctrl (
    .ref_clk(ref_clk), .rst_n(rst_n), .range_code(range_code),
    .meas_enable(meas_enable), .start_bit(start_bit), .lol_in(lol_in),
    .req_tgl(req_w), .cnt_hold(hold_w), .gate_o(gate_w), .done(done),
    .invalid(invalid), .lol_s(lol_sw), .result(result_w)
  );

  assign rate_hi     = res_hi(result_w);
  assign rate_mid    = res_mid(result_w);
  assign rate_lo     = res_lo(result_w);
  assign ratio_valid = done & ~invalid & ~lol_sw;

  // R3: the top byte never carries a bit above position 22
  p_hi_msb_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    rate_hi[7] == 1'b0);
endmodule

// File: tb/freq_ratio_meter_tb_top.sv
`timescale 1ps/1ps
module freq_ratio_meter_tb_top;
  localparam int TG = 5;
  localparam int TW = 12;
  localparam int NV = 6;
  // {range code, measured half period ps, expected count}
  localparam int VEC [NV][3] = '{
    '{0, 2500, 128},
    '{1, 1000, 640},
    '{2, 5000, 256},
    '{3, 2000, 1280},
    '{2, 625, 2048},
    '{3, 500, 4095}
  };

  logic ref_clk = 1'b0, meas_clk = 1'b0, ex_clk = 1'b0, rst_n = 1'b0;
  logic [1:0] range_code = 2'd0;
  logic meas_enable = 1'b1, start_bit = 1'b0, lol_in = 1'b0, ex_start = 1'b0;
  logic [7:0] rate_hi, rate_mid, rate_lo, ex_hi, ex_mid, ex_lo;
  logic done, invalid, ratio_valid, ex_done, ex_inv, ex_ok;
  int meas_half = 2500;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #10000 ref_clk = ~ref_clk;          // 50 MHz
  initial begin #137; forever #(meas_half) meas_clk = ~meas_clk; end
  always #256 ex_clk = ~ex_clk;              // 20000/512 = 39.0625 ratio

  freq_ratio_meter #(.GATE_LOG2(TG), .CNT_W(TW)) dut_i (
    .ref_clk(ref_clk), .meas_clk(meas_clk), .rst_n(rst_n), .range_code(range_code),
    .meas_enable(meas_enable), .start_bit(start_bit), .lol_in(lol_in),
    .rate_hi(rate_hi), .rate_mid(rate_mid), .rate_lo(rate_lo),
    .done(done), .invalid(invalid), .ratio_valid(ratio_valid)
  );

  freq_ratio_meter dut_ex_i (
    .ref_clk(ref_clk), .meas_clk(ex_clk), .rst_n(rst_n), .range_code(2'd1),
    .meas_enable(1'b1), .start_bit(ex_start), .lol_in(1'b0),
    .rate_hi(ex_hi), .rate_mid(ex_mid), .rate_lo(ex_lo),
    .done(ex_done), .invalid(ex_inv), .ratio_valid(ex_ok)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int read_rate();
    return {rate_hi[6:0], rate_mid, rate_lo};
  endfunction

  task automatic run_meas(input int code, input int lol_at);
    int len;
    len = 1 << (TG + code);
    @(negedge ref_clk) range_code = 2'(code);
    @(negedge ref_clk) start_bit = 1'b1;
    @(negedge ref_clk);
    check("R5 done while start high", int'(done), 0);
    check("R5 invalid while start high", int'(invalid), 0);
    start_bit = 1'b0;
    for (int k = 0; k < len - 2; k++) begin
      @(negedge ref_clk);
      if (k == lol_at) lol_in = 1'b1;
      if (k == lol_at + 6) lol_in = 1'b0;
    end
    check("R6 done low inside window", int'(done), 0);
    for (int k = 0; k < 80 && !done; k++) @(negedge ref_clk);
    check("R6 done after window", int'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge ref_clk);
    rst_n = 1'b1;
    @(negedge ref_clk);
    check("R6 reset done", int'(done), 0);
    check("R7 reset invalid", int'(invalid), 0);
    check("R10 reset ratio_valid", int'(ratio_valid), 0);
    check("R3 reset bytes", read_rate(), 0);

    // R1 worked check: 2^15 windows of 20 ns against 0.512 ns
    ex_start = 1'b1;
    repeat (2) @(negedge ref_clk);
    ex_start = 1'b0;
    for (int k = 0; k < 33000 && !ex_done; k++) @(negedge ref_clk);
    check("R1 worked check done", int'(ex_done), 1);
    check("R3 worked hi byte", int'(ex_hi), 'h13);
    check("R3 worked mid byte", int'(ex_mid), 'h88);
    check("R3 worked lo byte", int'(ex_lo), 'h00);

    // R2 / R8 table, enable held high throughout (R4 no re-arm)
    for (int i = 0; i < NV; i++) begin
      meas_half = VEC[i][1];
      repeat (3) @(negedge ref_clk);
      run_meas(VEC[i][0], -100);
      check(VEC[i][2] == 4095 ? "R8 saturated count" : "R2 count", read_rate(), VEC[i][2]);
      check("R3 hi bit7", int'(rate_hi[7]), 0);
      check("R10 clean result valid", int'(ratio_valid), 1);
    end

    // R4: start ignored with enable low; last result 4095 kept
    @(negedge ref_clk) meas_enable = 1'b0;
    start_bit = 1'b1;
    repeat (2) @(negedge ref_clk);
    start_bit = 1'b0;
    repeat (300) @(negedge ref_clk);
    check("R4 done kept with enable low", int'(done), 1);
    check("R4 result kept with enable low", read_rate(), 4095);
    meas_enable = 1'b1;

    // R7: loss of lock inside the window
    meas_half = 2500;
    run_meas(1, 20);
    check("R7 invalid latched", int'(invalid), 1);
    check("R10 invalid blocks valid", int'(ratio_valid), 0);
    check("R2 count with lol", read_rate(), 256);
    run_meas(1, -100);
    check("R7 invalid cleared by start", int'(invalid), 0);

    // R10: current lol drops ratio_valid
    @(negedge ref_clk) lol_in = 1'b1;
    repeat (4) @(negedge ref_clk);
    check("R10 lol now blocks valid", int'(ratio_valid), 0);
    lol_in = 1'b0;
    repeat (4) @(negedge ref_clk);
    check("R10 lol cleared valid", int'(ratio_valid), 1);

    // R9: range change mid-window aborts
    @(negedge ref_clk) range_code = 2'd2;
    @(negedge ref_clk) start_bit = 1'b1;
    @(negedge ref_clk) start_bit = 1'b0;
    repeat (20) @(negedge ref_clk);
    range_code = 2'd1;
    repeat (300) @(negedge ref_clk);
    check("R9 done low after abort", int'(done), 0);
    run_meas(1, -100);
    check("R9 fresh count after abort", read_rate(), 256);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule